// File: doc/BRIEF.md
# Multi-Channel Conversion Scan Sequencer

This block sits next to a conversion engine and decides which input channel is converted next. Each of the channels has an enable bit and a small index that selects one of the setup slots (filter, offset and gain settings kept elsewhere). The sequencer walks the enabled channels in ascending index order and issues one request per channel over a start/done handshake. After the highest enabled channel it goes back to the lowest one. Each finished conversion is posted to a result holder, together with the channel number and the setup slot that was used.

A mode register picks continuous scanning, which is the mode after reset, a single conversion, or standby. Writing the single mode starts one conversion on the lowest enabled channel. When that conversion completes, the block puts itself into standby. The enable mask and setup map are sampled only when a new request is issued, so a conversion in flight is never disturbed. A ready flag and an overrun flag tell the consumer whether a fresh result is waiting and whether an unread one was lost.

Top module: `scan_sequencer`

## Requirements
- R1: After reset the mode state is continuous (code 00), and both res_ready and res_overrun are 0.
- R2: In continuous mode, requests go to the enabled channels in ascending index order, one request per channel. After the highest enabled channel the scan wraps to the lowest enabled one. The scan position after a channel is that channel plus one, modulo the channel count.
- R3: conv_setup and res_setup equal the setup field of the requested channel, taken from ch_setup bits [2i+1:2i] for channel i at the cycle the request is issued.
- R4: One cycle after conv_done is accepted, res_ready is 1 and res_data, res_ch and res_setup hold the data, channel and setup of that conversion.
- R5: Writing mode code 01 (single) restarts the scan from the lowest enabled channel and issues exactly one request. In the cycle after that conversion's done, mode_state reads standby (10) and no further requests follow.
- R6: Mode codes 10 and 11 both select standby (mode_state 10). In standby no request is issued.
- R7: While ch_enable is all zero, no request is issued.
- R8: A change to ch_enable or ch_setup during a conversion leaves that conversion's channel and setup unchanged. The next request is chosen with the new values.
- R9: res_read clears res_ready and res_overrun in the next cycle. A result posted while res_ready is 1 and unread sets res_overrun.
- R10: conv_start is a single-cycle pulse, and no new request comes before the current one is done. A conv_done while no conversion is outstanding is ignored, and res_ready stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_enable | input | NUM_CH | Per-channel enable mask |
| ch_setup | input | NUM_CH*SETUP_W | Setup slot index per channel, field i at [SETUP_W*i +: SETUP_W] |
| mode_code | input | 2 | Mode to write: 00 continuous, 01 single, 10/11 standby |
| mode_wr | input | 1 | Writes mode_code into the mode register |
| conv_start | output | 1 | One-cycle conversion request |
| conv_ch | output | CH_W | Channel of the outstanding request |
| conv_setup | output | SETUP_W | Setup slot of the outstanding request |
| conv_done | input | 1 | Engine finished the outstanding conversion |
| conv_data | input | DATA_W | Engine result, valid with conv_done |
| res_read | input | 1 | Consumer has taken the posted result |
| res_data | output | DATA_W | Posted result |
| res_ch | output | CH_W | Channel of the posted result |
| res_setup | output | SETUP_W | Setup slot of the posted result |
| res_ready | output | 1 | An unread result is posted |
| res_overrun | output | 1 | An unread result was overwritten |
| mode_state | output | 2 | Current mode code |

## Verification
A request is chosen at the rising edge where the sequencer is idle, so conv_start, conv_ch and conv_setup are observed one cycle after the mask or mode write that allowed it. Results and flags appear one edge after conv_done or res_read. The single-to-standby change appears at that same edge. The bench drives inputs and samples outputs 1 ns after each falling edge. It keeps a model of the scan position, the restart condition, the mode and both flags, and checks every value in the cycle where the register feeding it has just updated. Random latencies, random read patterns and mid-conversion mask and setup changes are mixed with directed single-shot, standby, empty-mask and overrun cases.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

   typedef enum logic [1:0] {
      MODE_CONT    = 2'b00,
      MODE_SINGLE  = 2'b01,
      MODE_STANDBY = 2'b10
   } ssq_mode_e;

   function automatic ssq_mode_e decode_mode(input logic [1:0] code);
      case (code)
         2'b00:   return MODE_CONT;
         2'b01:   return MODE_SINGLE;
         default: return MODE_STANDBY;
      endcase
   endfunction

endpackage

// File: rtl/ssq_pick.sv
module ssq_pick #(
   parameter int NUM_CH = 4,
   parameter int CH_W   = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0] mask,
   input  logic [CH_W-1:0]   origin,
   output logic              found,
   output logic [CH_W-1:0]   pick
);

   generate
      if (NUM_CH < 2 || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_count
         $error("ssq_pick: NUM_CH must be a power of two and at least 2");
      end
   endgenerate

   logic [CH_W-1:0] cand;

   // Circular search from origin; scanning offsets downward lets the
   // smallest offset win.
   always_comb begin
      found = 1'b0;
      pick  = origin;
      cand  = origin;
      for (int k = NUM_CH - 1; k >= 0; k--) begin
         cand = origin + CH_W'(k);
         if (mask[cand]) begin
            found = 1'b1;
            pick  = cand;
         end
      end
   end

endmodule

// File: rtl/ssq_result.sv
module ssq_result #(
   parameter int DATA_W  = 24,
   parameter int CH_W    = 2,
   parameter int SETUP_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               post,
   input  logic [DATA_W-1:0]  post_data,
   input  logic [CH_W-1:0]    post_ch,
   input  logic [SETUP_W-1:0] post_setup,
   input  logic               rd,
   output logic [DATA_W-1:0]  data_q,
   output logic [CH_W-1:0]    ch_q,
   output logic [SETUP_W-1:0] setup_q,
   output logic               ready_q,
   output logic               ovr_q
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("ssq_result: DATA_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q  <= '0;
         ch_q    <= '0;
         setup_q <= '0;
         ready_q <= 1'b0;
         ovr_q   <= 1'b0;
      end else if (post) begin
         data_q  <= post_data;
         ch_q    <= post_ch;
         setup_q <= post_setup;
         ready_q <= 1'b1;
         ovr_q   <= (ready_q || ovr_q) && !rd;
      end else if (rd) begin
         ready_q <= 1'b0;
         ovr_q   <= 1'b0;
      end
   end

   AST_READY_AFTER_POST: assert property (@(posedge clk) disable iff (!rst_n)
      post |=> ready_q);  // R4
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !post) |=> (!ready_q && !ovr_q));  // R9
   AST_OVR_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
      (post && ready_q && !rd) |=> ovr_q);  // R9
   AST_OVR_IMPLIES_READY: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q |-> ready_q);  // R9

endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
   import ssq_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int NUM_SETUP = 4,
   parameter int DATA_W    = 24,
   parameter int CH_W      = $clog2(NUM_CH),
   parameter int SETUP_W   = $clog2(NUM_SETUP)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CH-1:0]         ch_enable,
   input  logic [NUM_CH*SETUP_W-1:0] ch_setup,
   input  logic [1:0]                mode_code,
   input  logic                      mode_wr,
   output logic                      conv_start,
   output logic [CH_W-1:0]           conv_ch,
   output logic [SETUP_W-1:0]        conv_setup,
   input  logic                      conv_done,
   input  logic [DATA_W-1:0]         conv_data,
   input  logic                      res_read,
   output logic [DATA_W-1:0]         res_data,
   output logic [CH_W-1:0]           res_ch,
   output logic [SETUP_W-1:0]        res_setup,
   output logic                      res_ready,
   output logic                      res_overrun,
   output logic [1:0]                mode_state
);

   generate
      if (NUM_SETUP < 2) begin : g_bad_setup
         $error("scan_sequencer: NUM_SETUP must be at least 2");
      end
      if (CH_W != $clog2(NUM_CH) || SETUP_W != $clog2(NUM_SETUP)) begin : g_bad_derived
         $error("scan_sequencer: CH_W and SETUP_W must stay at their derived values");
      end
   endgenerate

   // Split the flat setup map into one field per channel.
   logic [SETUP_W-1:0] setup_tbl [NUM_CH];
   generate
      for (genvar g = 0; g < NUM_CH; g++) begin : g_setup_field
         assign setup_tbl[g] = ch_setup[g*SETUP_W +: SETUP_W];
      end
   endgenerate

   ssq_mode_e          mode_q;
   ssq_mode_e          eff_mode;
   logic               busy_q;
   logic               start_q;
   logic               restart_q;
   logic [CH_W-1:0]    ptr_q;
   logic [CH_W-1:0]    cur_ch_q;
   logic [SETUP_W-1:0] cur_setup_q;

   logic [CH_W-1:0]    origin;
   logic               pick_found;
   logic [CH_W-1:0]    pick_idx;
   logic               pick_go;
   logic               done_acc;

   // A mode write acts at the edge where it is presented.
   assign eff_mode = mode_wr ? decode_mode(mode_code) : mode_q;
   assign origin   = (restart_q || mode_wr) ? '0 : ptr_q;
   assign pick_go  = !busy_q && (eff_mode != MODE_STANDBY) && pick_found;
   assign done_acc = busy_q && conv_done;

   ssq_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
      .mask   (ch_enable),
      .origin (origin),
      .found  (pick_found),
      .pick   (pick_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q      <= MODE_CONT;
         busy_q      <= 1'b0;
         start_q     <= 1'b0;
         restart_q   <= 1'b0;
         ptr_q       <= '0;
         cur_ch_q    <= '0;
         cur_setup_q <= '0;
      end else begin
         start_q <= pick_go;
         if (pick_go) begin
            busy_q      <= 1'b1;
            cur_ch_q    <= pick_idx;
            cur_setup_q <= setup_tbl[pick_idx];
            ptr_q       <= pick_idx + CH_W'(1);
         end else if (done_acc) begin
            busy_q <= 1'b0;
         end

         if (pick_go)      restart_q <= 1'b0;
         else if (mode_wr) restart_q <= 1'b1;

         if (mode_wr)
            mode_q <= decode_mode(mode_code);
         else if (done_acc && mode_q == MODE_SINGLE)
            mode_q <= MODE_STANDBY;
      end
   end

   assign conv_start = start_q;
   assign conv_ch    = cur_ch_q;
   assign conv_setup = cur_setup_q;
   assign mode_state = mode_q;

   ssq_result #(.DATA_W(DATA_W), .CH_W(CH_W), .SETUP_W(SETUP_W)) u_result (
      .clk        (clk),
      .rst_n      (rst_n),
      .post       (done_acc),
      .post_data  (conv_data),
      .post_ch    (cur_ch_q),
      .post_setup (cur_setup_q),
      .rd         (res_read),
      .data_q     (res_data),
      .ch_q       (res_ch),
      .setup_q    (res_setup),
      .ready_q    (res_ready),
      .ovr_q      (res_overrun)
   );

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q);  // R10
   AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !conv_done) |=> !start_q);  // R10
   AST_PICK_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      pick_go |-> ch_enable[pick_idx]);  // R2
   AST_EMPTY_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && ch_enable == '0) |=> !start_q);  // R7
   AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && mode_q == MODE_STANDBY && !mode_wr) |=> !start_q);  // R6
   AST_SINGLE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_acc && mode_q == MODE_SINGLE && !mode_wr) |=> (mode_q == MODE_STANDBY));  // R5
   AST_CHANNEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !conv_done) |=> ($stable(cur_ch_q) && $stable(cur_setup_q)));  // R8

endmodule

// File: tb/tb_scan_sequencer.sv
module tb_scan_sequencer;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  ch_enable;
   logic [7:0]  ch_setup;
   logic [1:0]  mode_code;
   logic        mode_wr;
   logic        conv_start;
   logic [1:0]  conv_ch;
   logic [1:0]  conv_setup;
   logic        conv_done;
   logic [23:0] conv_data;
   logic        res_read;
   logic [23:0] res_data;
   logic [1:0]  res_ch;
   logic [1:0]  res_setup;
   logic        res_ready;
   logic        res_overrun;
   logic [1:0]  mode_state;

   always #5 clk = ~clk;

   scan_sequencer dut (
      .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .ch_setup(ch_setup),
      .mode_code(mode_code), .mode_wr(mode_wr), .conv_start(conv_start),
      .conv_ch(conv_ch), .conv_setup(conv_setup), .conv_done(conv_done),
      .conv_data(conv_data), .res_read(res_read), .res_data(res_data),
      .res_ch(res_ch), .res_setup(res_setup), .res_ready(res_ready),
      .res_overrun(res_overrun), .mode_state(mode_state)
   );

   int         nchk = 0;
   int         nfail = 0;
   logic [3:0] cur_mask;
   logic [7:0] cur_setup;
   logic [1:0] exp_ptr;
   bit         restart_m;
   logic [1:0] exp_mode;
   bit         exp_ready;
   bit         exp_ovr;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_pick(input logic [3:0] m, input logic [1:0] s);
      for (int i = 0; i < 4; i++) begin
         logic [1:0] c;
         c = s + 2'(i);
         if (m[c]) return int'(c);
      end
      return -1;
   endfunction

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic set_map(input logic [3:0] m, input logic [7:0] s);
      cur_mask = m; cur_setup = s;
      ch_enable = m; ch_setup = s;
   endtask

   task automatic write_mode(input logic [1:0] code);
      mode_code = code;
      mode_wr = 1'b1;
      restart_m = 1'b1;
      exp_mode = (code == 2'b11) ? 2'b10 : code;
      step();
      mode_wr = 1'b0;
      check(mode_state == exp_mode, "R6", "mode_state after write", mode_state, exp_mode);
   endtask

   task automatic do_read();
      res_read = 1'b1;
      step();
      res_read = 1'b0;
      exp_ready = 0; exp_ovr = 0;
      check(res_ready == 1'b0, "R9", "ready after read", res_ready, 0);
      check(res_overrun == 1'b0, "R9", "overrun after read", res_overrun, 0);
   endtask

   task automatic expect_quiet(input int n, input string req);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         step();
         if (conv_start) seen++;
      end
      check(seen == 0, req, "requests while quiet", seen, 0);
   endtask

   task automatic run_conv(input int lat, input bit rd, input bit mid_en,
                           input logic [3:0] mid_mask, input logic [7:0] mid_setup);
      int          e;
      int          n = 0;
      logic [1:0]  es;
      logic [23:0] d;
      e = exp_pick(cur_mask, restart_m ? 2'd0 : exp_ptr);
      if (e < 0) begin
         check(0, "R2", "model found no channel", 0, 1);
         return;
      end
      es = cur_setup[2*e +: 2];
      while (!conv_start && n < 50) begin
         step();
         n++;
      end
      if (!conv_start) begin
         check(0, "R2", "request timeout", 0, 1);
         return;
      end
      check(conv_ch == 2'(e), "R2", "conv_ch", conv_ch, e);
      check(conv_setup == es, "R3", "conv_setup", conv_setup, es);
      exp_ptr = 2'(e + 1);
      restart_m = 0;
      if (mid_en) set_map(mid_mask, mid_setup);
      d = 24'($urandom);
      step();
      check(conv_start == 1'b0, "R10", "start pulse width", conv_start, 0);
      for (int i = 1; i < lat; i++) step();
      conv_done = 1'b1;
      conv_data = d;
      step();
      conv_done = 1'b0;
      exp_ovr = exp_ovr | exp_ready;
      exp_ready = 1;
      if (exp_mode == 2'b01) exp_mode = 2'b10;
      check(res_ready == 1'b1, "R4", "ready after done", res_ready, 1);
      check(res_data == d, "R4", "res_data", res_data, d);
      check(res_ch == 2'(e), "R8", "res_ch", res_ch, e);
      check(res_setup == es, "R3", "res_setup", res_setup, es);
      check(res_overrun == exp_ovr, "R9", "overrun", res_overrun, exp_ovr);
      check(mode_state == exp_mode, "R5", "mode after done", mode_state, exp_mode);
      if (rd) do_read();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL WDOG watchdog actual=%0d expected=%0d", 1, 0);
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 0; ch_enable = 0; ch_setup = 0; mode_code = 0; mode_wr = 0;
      conv_done = 0; conv_data = 0; res_read = 0;
      cur_mask = 0; cur_setup = 0; exp_ptr = 0; restart_m = 0;
      exp_mode = 2'b00; exp_ready = 0; exp_ovr = 0;
      repeat (4) step();
      rst_n = 1;
      step();
      check(mode_state == 2'b00, "R1", "mode after reset", mode_state, 0);
      check(res_ready == 1'b0, "R1", "ready after reset", res_ready, 0);
      check(res_overrun == 1'b0, "R1", "overrun after reset", res_overrun, 0);
      expect_quiet(5, "R7");

      // Directed scan over channels 0,1,3 with wrap (R2, R3).
      set_map(4'b1011, 8'b00_11_01_10);
      for (int i = 0; i < 7; i++) run_conv(1 + i % 3, 1, 0, 4'b0, 8'b0);

      // Overrun sequence (R9).
      run_conv(2, 0, 0, 4'b0, 8'b0);
      run_conv(1, 0, 0, 4'b0, 8'b0);
      run_conv(1, 1, 0, 4'b0, 8'b0);

      // Random scan with mid-conversion map changes (R8).
      for (int i = 0; i < 60; i++) begin
         run_conv(1 + int'($urandom % 4), bit'($urandom % 2), ($urandom % 3) == 0,
                  4'(($urandom % 15) + 1), 8'($urandom));
      end

      // Standby via code 11, spurious done ignored (R6, R10).
      run_conv(1, 0, 0, 4'b0, 8'b0);
      write_mode(2'b11);
      do_read();
      expect_quiet(10, "R6");
      conv_done = 1'b1; conv_data = 24'hABCDEF;
      step();
      conv_done = 1'b0;
      step();
      check(res_ready == 1'b0, "R10", "ready after stray done", res_ready, 0);

      // Single-shot: restart from lowest enabled, then standby (R5).
      set_map(4'b0110, 8'b10_01_11_00);
      write_mode(2'b01);
      run_conv(2, 1, 0, 4'b0, 8'b0);
      expect_quiet(8, "R5");
      write_mode(2'b01);
      run_conv(3, 1, 0, 4'b0, 8'b0);
      set_map(4'b1000, 8'b01_00_00_00);
      write_mode(2'b01);
      run_conv(1, 1, 0, 4'b0, 8'b0);
      expect_quiet(6, "R5");

      // Empty mask in continuous mode, then a single enabled channel (R7).
      set_map(4'b0000, 8'b00_11_00_00);
      write_mode(2'b00);
      expect_quiet(10, "R7");
      set_map(4'b0100, 8'b00_11_00_00);
      run_conv(2, 1, 0, 4'b0, 8'b0);
      run_conv(1, 1, 0, 4'b0, 8'b0);

      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule